// File: doc/BRIEF.md
# Dual-Port Transfer Byte Counter

This block keeps the 16-bit count of bytes left in a data transfer between a PC host and a local buffer memory. Two bus masters reach the count as a pair of byte registers: a microcontroller, which sets up and supervises transfers, and the PC host, which can post a maximum length and read back the value that was granted. A sequencer can also replace the whole count in one cycle, for example with a stored packet size or with a remainder length.

A write to a trigger address starts a transfer. While the transfer runs, the count steps down by one for each byte moved. A direction input selects the event that counts: host data reads when data flows from memory to the host, or buffer-memory writes when data flows from the host into memory. When the last byte moves, the count reaches zero, a one-cycle zero pulse is raised and the transfer stops by itself.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset the count is 0, `xferActive` is 0 and `countZero` is 0.
- R2: Address FF82h holds count bits 7..0 and FF83h holds bits 15..8. A byte write changes only its own half of the count, and the change is visible on the next clock.
- R3: Both the microcontroller port and the host port can write either byte register. Each port's read data shows the addressed byte combinationally, and shows 0 for any other address.
- R4: A `seqLoadEn` cycle replaces all 16 bits of the count with `seqLoadVal`.
- R5: When sources collide in one cycle, only the highest one updates the count. The order is microcontroller byte write, then sequencer load, then host byte write, then decrement.
- R6: A write from either port to FF84h starts a transfer (`xferActive` goes to 1) only if the count is nonzero. The written data has no effect on the count, and a read of FF84h returns 0.
- R7: With `dirToMem` = 0 and a transfer active, each `hostDataRd` cycle decrements the count by one, and `bufMemWr` is ignored.
- R8: With `dirToMem` = 1 and a transfer active, each `bufMemWr` cycle decrements the count by one, and `hostDataRd` is ignored.
- R9: While `xferActive` is 0, neither strobe changes the count.
- R10: A decrement from 1 to 0 clears `xferActive` and raises `countZero` for exactly one cycle, in the same cycle in which the count first reads 0.
- R11: The count never wraps below zero. A strobe that arrives while a transfer is active and the count is 0 leaves the count at 0 and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcuWrEn | input | 1 | Microcontroller write strobe |
| mcuAddr | input | 16 | Microcontroller address, used for reads and writes |
| mcuWrData | input | 8 | Microcontroller write byte |
| mcuRdData | output | 8 | Microcontroller read byte |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 16 | Host address, used for reads and writes |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte |
| seqLoadEn | input | 1 | Sequencer full-count load strobe |
| seqLoadVal | input | 16 | Sequencer load value |
| hostDataRd | input | 1 | One host data read completed (memory-to-host) |
| bufMemWr | input | 1 | One byte written into buffer memory (host-to-memory) |
| dirToMem | input | 1 | 1 selects host-to-memory, 0 selects memory-to-host |
| count | output | 16 | Current count |
| xferActive | output | 1 | Transfer in progress |
| countZero | output | 1 | One-cycle pulse when a decrement reaches zero |

## Verification
The hardest states to reach from the ports are the collisions: a byte write that lands in the same cycle as a counting strobe, and a count that is forced to zero in the middle of an active transfer so that the next strobe meets the saturation rule. The bench drives these on purpose. It fires all three writers in one cycle, pairs a host byte write with a host data read, and clears both bytes from the microcontroller port while the transfer flag is still set. It then steps the count down one strobe at a time so that the 1-to-0 edge, with its pulse and the drop of the transfer flag, falls in a known cycle.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  // Operation that the control selects for the count register this cycle
  typedef struct packed {
    logic loadSeq;   // replace whole count from sequencer
    logic wrLow;     // write low byte
    logic wrHigh;    // write high byte
    logic pickMcu;   // byte source is the microcontroller port
    logic dec;       // decrement by one
  } cntOp_t;
endpackage

// File: rtl/xfer_cnt_ctrl.sv
module xfer_cnt_ctrl
  import xfer_cnt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 16'hFF82,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 16'hFF83,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF84
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcuWrEn,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              seqLoadEn,
  input  logic              hostDataRd,
  input  logic              bufMemWr,
  input  logic              dirToMem,
  input  logic              cntZero,
  input  logic              cntOne,
  output cntOp_t            op,
  output logic              xferActive,
  output logic              countZero
);
  logic mcuLow, mcuHigh, mcuTrig;
  logic hostLow, hostHigh, hostTrig;
  logic countStrobe, trigger, lastByte;

  assign mcuLow   = mcuWrEn  && (mcuAddr  == LOW_ADDR);
  assign mcuHigh  = mcuWrEn  && (mcuAddr  == HIGH_ADDR);
  assign mcuTrig  = mcuWrEn  && (mcuAddr  == TRIG_ADDR);
  assign hostLow  = hostWrEn && (hostAddr == LOW_ADDR);
  assign hostHigh = hostWrEn && (hostAddr == HIGH_ADDR);
  assign hostTrig = hostWrEn && (hostAddr == TRIG_ADDR);

  assign countStrobe = dirToMem ? bufMemWr : hostDataRd;
  assign trigger     = mcuTrig || hostTrig;

  // Fixed priority: mcu byte write, sequencer, host byte write, decrement
  always_comb begin
    op = '0;
    if (mcuLow || mcuHigh) begin
      op.wrLow   = mcuLow;
      op.wrHigh  = mcuHigh;
      op.pickMcu = 1'b1;
    end else if (seqLoadEn) begin
      op.loadSeq = 1'b1;
    end else if (hostLow || hostHigh) begin
      op.wrLow  = hostLow;
      op.wrHigh = hostHigh;
    end else if (xferActive && countStrobe && !cntZero) begin
      op.dec = 1'b1;
    end
  end

  assign lastByte = op.dec && cntOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferActive <= 1'b0;
      countZero  <= 1'b0;
    end else begin
      countZero <= lastByte;
      if (!xferActive && trigger && !cntZero)
        xferActive <= 1'b1;
      else if (lastByte)
        xferActive <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_cnt_dp.sv
module xfer_cnt_dp
  import xfer_cnt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntOp_t            op,
  input  logic [DATA_W-1:0] mcuWrData,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [CNT_W-1:0]  seqLoadVal,
  output logic [CNT_W-1:0]  cnt,
  output logic              cntZero,
  output logic              cntOne
);
  logic [DATA_W-1:0] wrByte;
  logic [CNT_W-1:0]  nextCnt;

  assign wrByte = op.pickMcu ? mcuWrData : hostWrData;

  always_comb begin
    nextCnt = cnt;
    if (op.loadSeq) begin
      nextCnt = seqLoadVal;
    end else if (op.dec) begin
      nextCnt = cnt - 1'b1;
    end else begin
      if (op.wrLow)  nextCnt[DATA_W-1:0]     = wrByte;
      if (op.wrHigh) nextCnt[CNT_W-1:DATA_W] = wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nextCnt;
  end

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/xfer_cnt_rdmux.sv
module xfer_cnt_rdmux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 16'hFF82,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 16'hFF83,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    if (addr == LOW_ADDR)       rdData = cnt[DATA_W-1:0];
    else if (addr == HIGH_ADDR) rdData = cnt[CNT_W-1:DATA_W];
    else                        rdData = '0;
  end
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
  import xfer_cnt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 16'hFF82,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 16'hFF83,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF84,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcuWrEn,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic [DATA_W-1:0] mcuWrData,
  output logic [DATA_W-1:0] mcuRdData,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              seqLoadEn,
  input  logic [CNT_W-1:0]  seqLoadVal,
  input  logic              hostDataRd,
  input  logic              bufMemWr,
  input  logic              dirToMem,
  output logic [CNT_W-1:0]  count,
  output logic              xferActive,
  output logic              countZero
);
  cntOp_t cntOp;
  logic   cntZero, cntOne;

  xfer_cnt_ctrl #(
    .ADDR_W(ADDR_W), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR), .TRIG_ADDR(TRIG_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .mcuWrEn(mcuWrEn), .mcuAddr(mcuAddr),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .seqLoadEn(seqLoadEn), .hostDataRd(hostDataRd), .bufMemWr(bufMemWr),
    .dirToMem(dirToMem), .cntZero(cntZero), .cntOne(cntOne),
    .op(cntOp), .xferActive(xferActive), .countZero(countZero)
  );

  xfer_cnt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .op(cntOp),
    .mcuWrData(mcuWrData), .hostWrData(hostWrData), .seqLoadVal(seqLoadVal),
    .cnt(count), .cntZero(cntZero), .cntOne(cntOne)
  );

  // One read mux per bus port
  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [ADDR_W-1:0] portAddr;
    logic [DATA_W-1:0] portData;
    assign portAddr = (p == 0) ? mcuAddr : hostAddr;
    xfer_cnt_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
    ) u_rd (.addr(portAddr), .cnt(count), .rdData(portData));
  end

  assign mcuRdData  = g_rd[0].portData;
  assign hostRdData = g_rd[1].portData;
endmodule

// File: rtl/xfer_cnt_chk.sv
module xfer_cnt_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 16'hFF82,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 16'hFF83,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              mcuWrEn,
  input logic [ADDR_W-1:0] mcuAddr,
  input logic [DATA_W-1:0] mcuWrData,
  input logic              hostWrEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              seqLoadEn,
  input logic [CNT_W-1:0]  seqLoadVal,
  input logic              hostDataRd,
  input logic              bufMemWr,
  input logic              dirToMem,
  input logic [CNT_W-1:0]  count,
  input logic              xferActive,
  input logic              countZero
);
  logic mcuByteWr, hostByteWr, anyWr, selStrobe;
  assign mcuByteWr  = mcuWrEn  && (mcuAddr  == LOW_ADDR || mcuAddr  == HIGH_ADDR);
  assign hostByteWr = hostWrEn && (hostAddr == LOW_ADDR || hostAddr == HIGH_ADDR);
  assign anyWr      = mcuByteWr || hostByteWr || seqLoadEn;
  assign selStrobe  = dirToMem ? bufMemWr : hostDataRd;

  p_hold_inactive_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && !anyWr) |=> $stable(count));

  // covers both directions (R7 and R8)
  p_dec_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && selStrobe && !anyWr && count > 1) |=> (count == $past(count) - 1'b1));

  p_zero_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    countZero |-> (count == '0 && !xferActive));

  p_zero_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    countZero |=> !countZero);

  p_saturate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !anyWr) |=> (count == '0));

  p_mcu_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mcuWrEn && mcuAddr == LOW_ADDR && seqLoadEn) |=> (count[DATA_W-1:0] == $past(mcuWrData)));

  p_seq_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqLoadEn && !mcuByteWr) |=> (count == $past(seqLoadVal)));
endmodule

bind xfer_byte_counter xfer_cnt_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .mcuWrEn(mcuWrEn), .mcuAddr(mcuAddr), .mcuWrData(mcuWrData),
  .hostWrEn(hostWrEn), .hostAddr(hostAddr), .seqLoadEn(seqLoadEn), .seqLoadVal(seqLoadVal),
  .hostDataRd(hostDataRd), .bufMemWr(bufMemWr), .dirToMem(dirToMem),
  .count(count), .xferActive(xferActive), .countZero(countZero)
);

// File: tb/tb_xfer_byte_counter.sv
module tb_xfer_byte_counter;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_LOW  = 16'hFF82;
  localparam logic [15:0] A_HIGH = 16'hFF83;
  localparam logic [15:0] A_TRIG = 16'hFF84;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mcuWrEn = 1'b0, hostWrEn = 1'b0;
  logic [15:0] mcuAddr = '0, hostAddr = '0;
  logic [7:0]  mcuWrData = '0, hostWrData = '0;
  logic [7:0]  mcuRdData, hostRdData;
  logic        seqLoadEn = 1'b0;
  logic [15:0] seqLoadVal = '0;
  logic        hostDataRd = 1'b0, bufMemWr = 1'b0, dirToMem = 1'b0;
  logic [15:0] count;
  logic        xferActive, countZero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_byte_counter dut (
    .clk(clk), .rstN(rstN),
    .mcuWrEn(mcuWrEn), .mcuAddr(mcuAddr), .mcuWrData(mcuWrData), .mcuRdData(mcuRdData),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .seqLoadEn(seqLoadEn), .seqLoadVal(seqLoadVal),
    .hostDataRd(hostDataRd), .bufMemWr(bufMemWr), .dirToMem(dirToMem),
    .count(count), .xferActive(xferActive), .countZero(countZero)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive a one-cycle pulse set up before, clear at next negedge
  task automatic tick();
    @(negedge clk);
    mcuWrEn = 0; hostWrEn = 0; seqLoadEn = 0; hostDataRd = 0; bufMemWr = 0;
  endtask

  task automatic seqLoad(logic [15:0] v);
    seqLoadEn = 1; seqLoadVal = v; tick();
  endtask

  task automatic tReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 count", count, 16'h0);
    chk("R1 active", {15'b0, xferActive}, 16'h0);
    chk("R1 zero", {15'b0, countZero}, 16'h0);
  endtask

  task automatic tByteRw();
    mcuWrEn = 1; mcuAddr = A_LOW; mcuWrData = 8'h34; tick();
    chk("R2 low write", count, 16'h0034);
    hostWrEn = 1; hostAddr = A_HIGH; hostWrData = 8'h12; tick();
    chk("R3 host high write", count, 16'h1234);
    mcuWrEn = 1; mcuAddr = A_LOW; mcuWrData = 8'hAB; tick();
    chk("R2 low only", count, 16'h12AB);
    mcuAddr = A_HIGH; hostAddr = A_LOW; #1;
    chk("R3 mcu read high", {8'h0, mcuRdData}, 16'h0012);
    chk("R3 host read low", {8'h0, hostRdData}, 16'h00AB);
    hostAddr = A_TRIG; mcuAddr = 16'h1234; #1;
    chk("R6 trigger reads zero", {8'h0, hostRdData}, 16'h0);
    chk("R3 other addr zero", {8'h0, mcuRdData}, 16'h0);
  endtask

  task automatic tSeqLoad();
    seqLoad(16'hBEEF);
    chk("R4 seq load", count, 16'hBEEF);
  endtask

  task automatic tPriority();
    mcuWrEn = 1; mcuAddr = A_LOW; mcuWrData = 8'h11;
    seqLoadEn = 1; seqLoadVal = 16'h5555;
    hostWrEn = 1; hostAddr = A_HIGH; hostWrData = 8'h77; tick();
    chk("R5 mcu wins", count, 16'hBE11);
    seqLoadEn = 1; seqLoadVal = 16'h2222;
    hostWrEn = 1; hostAddr = A_LOW; hostWrData = 8'h99; tick();
    chk("R5 seq over host", count, 16'h2222);
  endtask

  task automatic tTriggerZero();
    seqLoad(16'h0000);
    mcuWrEn = 1; mcuAddr = A_TRIG; mcuWrData = 8'hFF; tick();
    chk("R6 no start at zero", {15'b0, xferActive}, 16'h0);
  endtask

  task automatic tInactive();
    seqLoad(16'h0007);
    dirToMem = 0; hostDataRd = 1; tick();
    chk("R9 no dec inactive rd", count, 16'h0007);
    dirToMem = 1; bufMemWr = 1; tick();
    chk("R9 no dec inactive wr", count, 16'h0007);
  endtask

  task automatic tTransfer();
    seqLoad(16'h0003);
    dirToMem = 0;
    hostWrEn = 1; hostAddr = A_TRIG; hostWrData = 8'h5A; tick();
    chk("R6 started", {15'b0, xferActive}, 16'h1);
    chk("R6 data discarded", count, 16'h0003);
    bufMemWr = 1; tick();
    chk("R7 bufMemWr ignored", count, 16'h0003);
    hostDataRd = 1; tick();
    chk("R7 dec on read", count, 16'h0002);
    hostWrEn = 1; hostAddr = A_LOW; hostWrData = 8'h05; hostDataRd = 1; tick();
    chk("R5 host write over dec", count, 16'h0005);
    dirToMem = 1;
    hostDataRd = 1; tick();
    chk("R8 hostDataRd ignored", count, 16'h0005);
    bufMemWr = 1; tick();
    chk("R8 dec on buf write", count, 16'h0004);
    for (int i = 0; i < 3; i++) begin
      bufMemWr = 1; tick();
    end
    chk("R8 at one", count, 16'h0001);
    chk("R10 still active", {15'b0, xferActive}, 16'h1);
    bufMemWr = 1; tick();
    chk("R10 count zero", count, 16'h0000);
    chk("R10 pulse", {15'b0, countZero}, 16'h1);
    chk("R10 ends xfer", {15'b0, xferActive}, 16'h0);
    tick();
    chk("R10 pulse one cycle", {15'b0, countZero}, 16'h0);
  endtask

  task automatic tSaturate();
    seqLoad(16'h0002);
    dirToMem = 0;
    mcuWrEn = 1; mcuAddr = A_TRIG; tick();
    mcuWrEn = 1; mcuAddr = A_LOW; mcuWrData = 8'h00; tick();
    mcuWrEn = 1; mcuAddr = A_HIGH; mcuWrData = 8'h00; tick();
    chk("R11 active with zero", {15'b0, xferActive}, 16'h1);
    hostDataRd = 1; tick();
    chk("R11 no wrap", count, 16'h0000);
    chk("R11 no pulse", {15'b0, countZero}, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tReset();
    tByteRw();
    tSeqLoad();
    tPriority();
    tTriggerZero();
    tInactive();
    tTransfer();
    tSaturate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule